// File: doc/BRIEF.md
# Nested Vectored Priority Resolver

This block sits after the masking stage of an interrupt controller. It takes the vector of enabled IRQ requests and sorts them into a row of programmable priority slots. Each slot names one request source. A last, unvectored level catches everything that no slot claims. The block drives the IRQ line toward the processor. When software reads the acknowledge register, the block returns the handler address of the winning level.

It also tracks nesting. The acknowledge read raises the current priority level and stores the level it came from. While a handler runs, only sources that belong to more urgent slots can assert the IRQ line again. An end-of-interrupt write to the same register returns to the stored level.

Software reaches the slot tables, the default vector and the acknowledge register over a simple word-addressed register port. Read data is combinational in the cycle of the read, and state changes take effect at the next clock edge.

Top module: `nvec_prio_resolver`

## Requirements
- R1: After reset the current level is idle (17), every vector address and slot control field reads as zero, and the default vector reads as zero.
- R2: A slot control word keeps only bits 5:0. Bit 5 enables the slot and bits 4:0 name the source it claims. A disabled slot contributes no source to any mask, and bits written above bit 5 read back as zero.
- R3: The mask of level i (0..16) is the union of the sources of the enabled slots with index below i. The mask of the idle level 17 has all bits set.
- R4: `irq_out` is high in the same cycle exactly when `irq_status` ANDed with the mask of the current level is nonzero.
- R5: A read of word 12 scans levels 0 up to current-1. For the first level whose mask overlaps `irq_status`, it returns that level's vector address in the same cycle. At the next edge it stores the old current level in that level's saved entry and makes that level current.
- R6: If the scan finds no level, the read of word 12 returns the vector of the current level, or the default vector when the current level is 16 or idle, and the current level does not change.
- R7: A write to word 12 ignores its data. Below idle, it sets the current level to that level's saved entry. At idle it has no effect.
- R8: A read and a write of word 12 in the same cycle act as the read followed by the write. After a scan hit, the current level is therefore unchanged.
- R9: Vector address i is at word 0x40+i, slot control i is at word 0x80+i, and the default vector is at word 13. All are read/write. Other words read as zero, and writes to them are ignored.
- R10: Nested acknowledges stack. A more urgent source can preempt a running handler, a less urgent one cannot raise `irq_out`, and successive end-of-interrupt writes unwind the levels in reverse order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_status | input | 32 | Enabled, non-FIQ request vector from the masking stage |
| reg_addr | input | 10 | Word address of the register access |
| reg_rd | input | 1 | Read strobe |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, valid in the cycle of `reg_rd` |
| irq_out | output | 1 | IRQ request to the processor |

## Verification
`irq_out` and `reg_rdata` are combinational from the current inputs and the registered state, so they are due in the same cycle as the stimulus. The bench drives each access on the falling edge and compares both outputs one time unit later against a behavioural model. Register writes, level changes and saved entries appear from the next rising edge on. The model therefore applies its updates only after that edge, and the next cycle's comparison sees the new level. Directed nesting sequences check literal vectors. A long random phase then compares the model on every clock.

// File: rtl/nvpr_pkg.sv
package nvpr_pkg;
   localparam int unsigned ACK_WORD = 12;
   localparam int unsigned DEF_WORD = 13;
   localparam int unsigned VEC_BASE = 'h40;
   localparam int unsigned CTL_BASE = 'h80;
   localparam int unsigned MAX_SLOTS = 64;
endpackage

// File: rtl/nvpr_mask_chain.sv
module nvpr_mask_chain #(
   parameter int NUM_SLOTS = 16,
   parameter int SRC_W     = 5,
   localparam int NSRC     = 1 << SRC_W,
   localparam int CTL_W    = SRC_W + 1
) (
   input  logic [NUM_SLOTS-1:0][CTL_W-1:0] slot_ctl,
   output logic [NUM_SLOTS+1:0][NSRC-1:0]  lvl_mask
);
   logic [NUM_SLOTS-1:0][NSRC-1:0] slot_bit;

   for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
      assign slot_bit[g] = slot_ctl[g][SRC_W] ? (NSRC'(1) << slot_ctl[g][SRC_W-1:0]) : '0;
   end

   always_comb begin
      logic [NSRC-1:0] acc;
      acc = '0;
      for (int i = 0; i < NUM_SLOTS; i++) begin
         lvl_mask[i] = acc;
         acc = acc | slot_bit[i];
      end
      lvl_mask[NUM_SLOTS]   = acc;
      lvl_mask[NUM_SLOTS+1] = '1;
   end
endmodule

// File: rtl/nvpr_ack_scan.sv
module nvpr_ack_scan #(
   parameter int NLVL  = 17,
   parameter int NSRC  = 32,
   parameter int LVL_W = 5
) (
   input  logic [NLVL-1:0][NSRC-1:0] lvl_mask,
   input  logic [NSRC-1:0]           pend,
   input  logic [LVL_W-1:0]          cur_lvl,
   output logic                      hit,
   output logic [LVL_W-1:0]          hit_lvl
);
   logic [NLVL-1:0] cand;

   for (genvar g = 0; g < NLVL; g++) begin : g_cand
      assign cand[g] = (LVL_W'(g) < cur_lvl) && (|(lvl_mask[g] & pend));
   end

   always_comb begin
      hit     = 1'b0;
      hit_lvl = '0;
      for (int i = NLVL - 1; i >= 0; i--) begin
         if (cand[i]) begin
            hit     = 1'b1;
            hit_lvl = LVL_W'(i);
         end
      end
   end
endmodule

// File: rtl/nvec_prio_resolver.sv
module nvec_prio_resolver #(
   parameter int NUM_SLOTS = 16,
   parameter int SRC_W     = 5,
   parameter int DATA_W    = 32,
   parameter int ADDR_W    = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [(1<<SRC_W)-1:0] irq_status,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic              reg_rd,
   input  logic              reg_wr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   output logic              irq_out
);
   import nvpr_pkg::*;

   localparam int NSRC   = 1 << SRC_W;
   localparam int CTL_W  = SRC_W + 1;
   localparam int NLVL   = NUM_SLOTS + 1;
   localparam int IDLE   = NUM_SLOTS + 1;
   localparam int LVL_W  = $clog2(IDLE + 1);
   localparam int SLOT_W = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1;

   if (NUM_SLOTS < 1 || NUM_SLOTS > MAX_SLOTS) begin : g_bad_slots
      $error("NUM_SLOTS out of range");
   end
   if (DATA_W < CTL_W) begin : g_bad_data
      $error("DATA_W too narrow for control field");
   end
   if ((1 << ADDR_W) <= (CTL_BASE + NUM_SLOTS)) begin : g_bad_addr
      $error("ADDR_W too narrow for register map");
   end

   logic [DATA_W-1:0]                vec_q [NLVL];
   logic [NUM_SLOTS-1:0][CTL_W-1:0]  ctl_q;
   logic [LVL_W-1:0]                 saved_q [NLVL];
   logic [LVL_W-1:0]                 cur_q, cur_d;
   logic [NUM_SLOTS+1:0][NSRC-1:0]   lvl_mask;
   logic                             ack_hit;
   logic [LVL_W-1:0]                 ack_lvl;

   nvpr_mask_chain #(.NUM_SLOTS(NUM_SLOTS), .SRC_W(SRC_W)) u_masks (
      .slot_ctl (ctl_q),
      .lvl_mask (lvl_mask)
   );

   nvpr_ack_scan #(.NLVL(NLVL), .NSRC(NSRC), .LVL_W(LVL_W)) u_scan (
      .lvl_mask (lvl_mask[NLVL-1:0]),
      .pend     (irq_status),
      .cur_lvl  (cur_q),
      .hit      (ack_hit),
      .hit_lvl  (ack_lvl)
   );

   // Address decode
   logic              ack_sel, def_sel, vec_sel, ctl_sel;
   logic [SLOT_W-1:0] vec_idx, ctl_idx;
   assign ack_sel = (reg_addr == ADDR_W'(ACK_WORD));
   assign def_sel = (reg_addr == ADDR_W'(DEF_WORD));
   assign vec_sel = (reg_addr >= ADDR_W'(VEC_BASE)) && (reg_addr < ADDR_W'(VEC_BASE + NUM_SLOTS));
   assign ctl_sel = (reg_addr >= ADDR_W'(CTL_BASE)) && (reg_addr < ADDR_W'(CTL_BASE + NUM_SLOTS));
   assign vec_idx = SLOT_W'(reg_addr - ADDR_W'(VEC_BASE));
   assign ctl_idx = SLOT_W'(reg_addr - ADDR_W'(CTL_BASE));

   logic ack_rd, ack_wr;
   assign ack_rd = reg_rd && ack_sel;
   assign ack_wr = reg_wr && ack_sel;

   // Acknowledge read data: winning level, else current level, else default
   logic [DATA_W-1:0] ack_data;
   always_comb begin
      if (ack_hit)
         ack_data = vec_q[ack_lvl];
      else if (cur_q >= LVL_W'(NUM_SLOTS))
         ack_data = vec_q[NUM_SLOTS];
      else
         ack_data = vec_q[cur_q];
   end

   always_comb begin
      reg_rdata = '0;
      if (reg_rd) begin
         if (ack_sel)      reg_rdata = ack_data;
         else if (def_sel) reg_rdata = vec_q[NUM_SLOTS];
         else if (vec_sel) reg_rdata = vec_q[vec_idx];
         else if (ctl_sel) reg_rdata = DATA_W'(ctl_q[ctl_idx]);
      end
   end

   // Level sequencing: read effect first, then end-of-interrupt
   logic             save_en;
   logic [LVL_W-1:0] lvl_mid;
   always_comb begin
      save_en = ack_rd && ack_hit;
      lvl_mid = save_en ? ack_lvl : cur_q;
      cur_d   = lvl_mid;
      if (ack_wr && lvl_mid < LVL_W'(IDLE))
         cur_d = save_en ? cur_q : saved_q[lvl_mid];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q <= LVL_W'(IDLE);
         ctl_q <= '0;
         for (int i = 0; i < NLVL; i++) begin
            vec_q[i]   <= '0;
            saved_q[i] <= LVL_W'(IDLE);
         end
      end else begin
         cur_q <= cur_d;
         if (save_en)
            saved_q[ack_lvl] <= cur_q;
         if (reg_wr && def_sel)
            vec_q[NUM_SLOTS] <= reg_wdata;
         if (reg_wr && vec_sel)
            vec_q[vec_idx] <= reg_wdata;
         if (reg_wr && ctl_sel)
            ctl_q[ctl_idx] <= reg_wdata[CTL_W-1:0];
      end
   end

   assign irq_out = |(irq_status & lvl_mask[cur_q]);
endmodule

// File: rtl/nvpr_checker.sv
module nvpr_checker #(
   parameter int NUM_SLOTS = 16,
   parameter int SRC_W     = 5,
   parameter int ADDR_W    = 10,
   localparam int IDLE     = NUM_SLOTS + 1,
   localparam int LVL_W    = $clog2(IDLE + 1)
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [(1<<SRC_W)-1:0] irq_status,
   input logic [ADDR_W-1:0]    reg_addr,
   input logic                 reg_rd,
   input logic                 reg_wr,
   input logic                 irq_out,
   input logic [LVL_W-1:0]     cur_lvl,
   input logic                 hit
);
   logic a_rd, a_wr;
   assign a_rd = reg_rd && reg_addr == ADDR_W'(nvpr_pkg::ACK_WORD);
   assign a_wr = reg_wr && reg_addr == ADDR_W'(nvpr_pkg::ACK_WORD);

   AST_LVL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      cur_lvl <= LVL_W'(IDLE)); // R7
   AST_IDLE_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      cur_lvl == LVL_W'(IDLE) |-> irq_out == (|irq_status)); // R3
   AST_ACK_RAISE: assert property (@(posedge clk) disable iff (!rst_n)
      a_rd && hit && !a_wr |=> cur_lvl < $past(cur_lvl)); // R5
   AST_NO_ACCESS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !a_rd && !a_wr |=> $stable(cur_lvl)); // R6
   AST_EOI_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      a_wr && !a_rd && cur_lvl == LVL_W'(IDLE) |=> cur_lvl == LVL_W'(IDLE)); // R7
   AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      a_rd && a_wr && hit |=> $stable(cur_lvl)); // R8
endmodule

bind nvec_prio_resolver nvpr_checker #(
   .NUM_SLOTS(NUM_SLOTS), .SRC_W(SRC_W), .ADDR_W(ADDR_W)
) u_chk (
   .clk(clk), .rst_n(rst_n), .irq_status(irq_status), .reg_addr(reg_addr),
   .reg_rd(reg_rd), .reg_wr(reg_wr), .irq_out(irq_out),
   .cur_lvl(cur_q), .hit(ack_hit)
);

// File: tb/test_nvec_prio_resolver.sv
module test_nvec_prio_resolver;
   logic        clk = 0;
   logic        rst_n = 0;
   logic [31:0] irq_status = 0;
   logic [9:0]  reg_addr = 0;
   logic        reg_rd = 0, reg_wr = 0;
   logic [31:0] reg_wdata = 0;
   logic [31:0] reg_rdata;
   logic        irq_out;

   int n_tests = 0, n_fail = 0;
   bit done = 0;
   logic [31:0] last_rd;

   // behavioural model state
   int          m_prio;
   int          m_saved [18];
   logic [31:0] m_vec [17];
   int          m_ctl [16];

   always #4 clk = ~clk;

   nvec_prio_resolver i_nvec_prio_resolver (
      .clk(clk), .rst_n(rst_n), .irq_status(irq_status), .reg_addr(reg_addr),
      .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .irq_out(irq_out)
   );

   function automatic logic [31:0] m_mask(int lvl);
      logic [31:0] m = 0;
      if (lvl >= 17) return 32'hFFFF_FFFF;
      for (int i = 0; i < lvl && i < 16; i++)
         if (m_ctl[i] & 32) m |= 32'd1 << (m_ctl[i] & 31);
      return m;
   endfunction

   function automatic int m_scan(logic [31:0] st);
      for (int i = 0; i < m_prio; i++)
         if ((st & m_mask(i)) != 0) return i;
      return -1;
   endfunction

   task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      m_prio = 17;
      foreach (m_saved[i]) m_saved[i] = 17;
      foreach (m_vec[i]) m_vec[i] = 0;
      foreach (m_ctl[i]) m_ctl[i] = 0;
   endtask

   // One clock: drive on falling edge, compare outputs, update model after rising edge
   task automatic cycle(bit rd, bit wr, int addr, logic [31:0] wd, logic [31:0] st);
      int lvl;
      logic [31:0] exp_rd;
      string tag;
      @(negedge clk);
      reg_rd = rd; reg_wr = wr; reg_addr = 10'(addr); reg_wdata = wd; irq_status = st;
      #1;
      chk("R4 irq_out", {31'b0, irq_out}, {31'b0, (st & m_mask(m_prio)) != 0});
      lvl = m_scan(st);
      if (rd) begin
         exp_rd = 0; tag = "R9 rdata";
         if (addr == 12) begin
            if (lvl >= 0) begin exp_rd = m_vec[lvl]; tag = "R5 ack data"; end
            else begin exp_rd = (m_prio >= 16) ? m_vec[16] : m_vec[m_prio]; tag = "R6 ack data"; end
         end else if (addr == 13) exp_rd = m_vec[16];
         else if (addr >= 'h40 && addr < 'h50) exp_rd = m_vec[addr - 'h40];
         else if (addr >= 'h80 && addr < 'h90) exp_rd = 32'(m_ctl[addr - 'h80]);
         last_rd = reg_rdata;
         chk(tag, reg_rdata, exp_rd);
      end
      @(posedge clk);
      if (rd && addr == 12 && lvl >= 0) begin
         m_saved[lvl] = m_prio;
         m_prio = lvl;
      end
      if (wr) begin
         if (addr == 12 && m_prio < 17) m_prio = m_saved[m_prio];
         else if (addr == 13) m_vec[16] = wd;
         else if (addr >= 'h40 && addr < 'h50) m_vec[addr - 'h40] = wd;
         else if (addr >= 'h80 && addr < 'h90) m_ctl[addr - 'h80] = int'(wd & 32'h3F);
      end
   endtask

   task automatic rd(int a, logic [31:0] st);  cycle(1, 0, a, 0, st); endtask
   task automatic wr(int a, logic [31:0] d);  cycle(0, 1, a, d, 0);  endtask

   initial begin
      #(8 * 200000);
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1;
      // R1 reset state
      rd(12, 0);      chk("R1 ack idle default", last_rd, 32'h0);
      rd('h45, 0);    chk("R1 vector zero", last_rd, 32'h0);
      rd('h83, 0);    chk("R1 control zero", last_rd, 32'h0);
      rd(13, 0);      chk("R1 default zero", last_rd, 32'h0);
      rd(5, 32'h1);   // R3 idle mask: any request raises irq (checked in cycle)
      // R9 programming
      for (int i = 0; i < 16; i++) wr('h40 + i, 32'h1000 + 16 * i);
      wr(13, 32'hDEF0);
      wr('h80, 32'h23); wr('h81, 32'h27); wr('h82, 32'h2A);
      wr('h83, 32'h0C); wr('h84, 32'hFF);
      wr(7, 32'h1234);
      rd(7, 0);       chk("R9 unmapped reads zero", last_rd, 32'h0);
      rd('h84, 0);    chk("R2 upper bits dropped", last_rd, 32'h3F);
      rd('h47, 0);    chk("R9 vector readback", last_rd, 32'h1070);
      // R2 disabled slot source 12 not claimed -> default vector
      rd(12, 32'h1000); chk("R2 disabled slot", last_rd, 32'hDEF0);
      // R5 source 10 hits level 3
      rd(12, 32'h400);  chk("R5 level3 vector", last_rd, 32'h1030);
      // R10 source 3 preempts, source 10 alone is masked
      rd(12, 32'h408);  chk("R10 preempt vector", last_rd, 32'h1010);
      rd(2, 32'h400);   // irq_out must be low at level 1 (R10, checked in cycle)
      // R7 unwind
      cycle(0, 1, 12, 32'hFFFF_FFFF, 0);
      rd(12, 0);        chk("R7 restored level3", last_rd, 32'h1030);
      wr(12, 0);
      rd(12, 0);        chk("R7 restored idle", last_rd, 32'hDEF0);
      wr(12, 0);
      rd(12, 0);        chk("R7 idle eoi no effect", last_rd, 32'hDEF0);
      // R8 simultaneous read and write
      cycle(1, 1, 12, 0, 32'h400); chk("R8 read data", last_rd, 32'h1030);
      rd(12, 0);        chk("R8 level unchanged", last_rd, 32'hDEF0);
      rd(12, 32'h400);  chk("R8 later hit", last_rd, 32'h1030);
      wr(12, 0);
      // random phase, model compared every clock
      for (int n = 0; n < 4000; n++) begin
         int a, k;
         logic [31:0] st;
         k = $urandom % 8;
         case (k)
            0, 1, 2: a = 12;
            3: a = 13;
            4: a = 'h40 + $urandom % 16;
            5: a = 'h80 + $urandom % 16;
            default: a = $urandom % 1024;
         endcase
         st = $urandom & $urandom & $urandom;
         cycle(($urandom % 2) == 1, ($urandom % 3) == 0, a,
               (k == 5) ? ($urandom & 32'h3F) : $urandom, st);
      end
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule